// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses through a fully associative table of page mappings. The upper 20 bits of an address form the virtual page number and the lower 12 bits are the page offset, which passes straight through. An entry takes part in a translation when its page number equals the address's page number and it is either marked global or tagged with the address-space identifier currently held in the tag register. When no usable entry exists, the block raises a miss instead of a translation and records the faulting address.

Hardware never refills the table. Control software loads the tag and data registers, then issues one of four commands: copy an entry into the registers, store the registers at a slot named by the slot register, store them at a slot chosen by a free-running down-counter, or search the table for the tag register's contents. Slots below the counter's floor are never chosen by the counter, so software can reserve them for permanent mappings.

Translation requests may come from instruction fetches or from loads and stores; a store flag selects the write-permission check. Results appear one clock after the request.

Top module: `tlb_mmu`

## Requirements
- R1: A request with `xl_valid` high yields, one clock later, `xl_done` high and, on a successful translation, `xl_paddr` equal to the entry's 20-bit frame number followed by the request's unchanged low 12 bits, with `xl_uncached` equal to the entry's non-cacheable bit.
- R2: An entry matches only when its page number equals `xl_vaddr[31:12]` and either its global bit is set or its identifier equals the identifier in the tag register (bits 11:6); any other entry is ignored.
- R3: When no entry matches, or the selected matching entry has its valid bit clear, the result has `xl_miss` high, `xl_mod` low and `xl_paddr` zero.
- R4: On a miss or a write-permission fault the full request address is stored in the fault-address register (number 8); after a successful translation that register is unchanged.
- R5: A store request (`xl_store` high) to a matching valid entry with its dirty bit clear gives `xl_mod` high, `xl_miss` low and `xl_paddr` zero; a load to the same entry translates normally.
- R6: Command 0 (read) loads the tag register and data register from the slot named by the slot register.
- R7: Command 1 (indexed write) stores the tag and data registers into the slot named by the slot register.
- R8: Command 2 (random write) stores them into the slot named by the counter's value in that same cycle.
- R9: Command 3 (probe) searches with the tag register's page number and identifier; on a match the slot register reads the matching slot in bits 13:8 with bit 31 clear, otherwise it reads exactly 0x8000_0000.
- R10: The counter (register 1, bits 13:8) reads 63 after reset, decreases by one every clock, and after reading 8 returns to 63.
- R11: When several entries match, the lowest-numbered one decides the lookup and the probe result.
- R12: Register numbers are slot 0, counter 1, data 2, fault address 8, tag 10; the tag word is page number 31:12 and identifier 11:6, the data word is frame 31:12, non-cacheable 11, dirty 10, valid 9, global 8; unlisted bits read zero, and writes to the counter or fault-address register have no effect.
- R13: After reset all registers read zero except the counter, and every entry is invalid, so any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_valid | input | 1 | Translation request strobe |
| xl_store | input | 1 | Request is a store |
| xl_vaddr | input | 32 | Virtual address to translate |
| xl_done | output | 1 | Result valid, one clock after request |
| xl_miss | output | 1 | Translation miss |
| xl_mod | output | 1 | Store to a page without write permission |
| xl_uncached | output | 1 | Translated page is non-cacheable |
| xl_paddr | output | 32 | Physical address, zero on any fault |
| op_valid | input | 1 | Management command strobe |
| op_code | input | 2 | 0 read, 1 indexed write, 2 random write, 3 probe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register, combinational |

## Verification
The bench fills all 64 slots with mixed global and private mappings and translates each at the first, last and an arbitrary offset of its page, since a design that compared offset bits or dropped them would fail at one of those. Switching the current identifier exposes a design that ignores the global bit or the identifier, which would then hit private pages or miss global ones. Shadowing entries show whether the lowest slot wins, including an invalid low slot that must force a miss, and the counter is followed across several wraps where an off-by-one floor would pick a reserved slot. Probes that miss must clear the slot field, and stores to clean pages must fault while loads to them translate.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PFN_W    = 20;
    localparam int ASID_W   = 6;
    localparam int ASID_LSB = 6;
    localparam int SLOT_LSB = 8;

    localparam logic [4:0] CP_SLOT  = 5'd0;
    localparam logic [4:0] CP_RAND  = 5'd1;
    localparam logic [4:0] CP_DATA  = 5'd2;
    localparam logic [4:0] CP_FAULT = 5'd8;
    localparam logic [4:0] CP_TAG   = 5'd10;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WIDX  = 2'd1,
        OP_WRND  = 2'd2,
        OP_PROBE = 2'd3
    } tlb_op_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
    } tlb_tag_t;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             nc;
        logic             dirty;
        logic             valid;
        logic             glob;
    } tlb_data_t;

    typedef struct packed {
        tlb_tag_t  tag;
        tlb_data_t data;
    } tlb_entry_t;

    function automatic logic [31:0] pack_tag(input tlb_tag_t t);
        return {t.vpn, t.asid, 6'b0};
    endfunction

    function automatic logic [31:0] pack_data(input tlb_data_t d);
        return {d.pfn, d.nc, d.dirty, d.valid, d.glob, 8'b0};
    endfunction

    function automatic logic tag_hit(input tlb_entry_t e,
                                     input logic [VPN_W-1:0] vpn,
                                     input logic [ASID_W-1:0] asid);
        return (e.tag.vpn == vpn) && (e.data.glob || (e.tag.asid == asid));
    endfunction

endpackage

// File: rtl/tlb_random_ctr.sv
module tlb_random_ctr #(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8,
    localparam int W      = $clog2(ENTRIES)
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP   = W'(ENTRIES - 1);
    localparam logic [W-1:0] FLOOR = W'(WIRED);

    always_ff @(posedge clk) begin
        if (rst)
            value <= TOP;
        else if (value <= FLOOR)
            value <= TOP;
        else
            value <= value - 1'b1;
    end

    assert_rand_range_R10: assert property (@(posedge clk) disable iff (rst)
        (value >= FLOOR) && (value <= TOP));

    assert_rand_step_R10: assert property (@(posedge clk) disable iff (rst)
        (value != FLOOR) |=> (value == $past(value) - 1'b1));

    assert_rand_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (value == FLOOR) |=> (value == TOP));

endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N = 64,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] match,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = i[W-1:0];
            end
        end
    end

    always_comb begin
        assert_sel_matches_R11: assert (!hit || match[idx]);
        assert_none_lower_R11: assert (!hit || ((match & ((N'(1) << idx) - N'(1))) == '0));
        assert_hit_any_R11: assert (hit == (match != '0));
    end

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int W      = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [W-1:0]          widx,
    input  tlb_entry_t            wentry,
    input  logic [VPN_W-1:0]      look_vpn,
    input  logic [VPN_W-1:0]      probe_vpn,
    input  logic [ASID_W-1:0]     asid,
    output tlb_entry_t            ent_q [ENTRIES],
    output logic [ENTRIES-1:0]    look_match,
    output logic [ENTRIES-1:0]    probe_match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ent_q[g] <= '0;
            else if (we && (widx == W'(g)))
                ent_q[g] <= wentry;
        end

        assign look_match[g]  = tag_hit(ent_q[g], look_vpn, asid);
        assign probe_match[g] = tag_hit(ent_q[g], probe_vpn, asid);

        assert_slot_write_R7: assert property (@(posedge clk) disable iff (rst)
            (we && (widx == W'(g))) |=> (ent_q[g] == $past(wentry)));

        assert_slot_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !(we && (widx == W'(g))) |=> $stable(ent_q[g]));
    end

endmodule

// File: rtl/tlb_mmu.sv
module tlb_mmu
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xl_valid,
    input  logic        xl_store,
    input  logic [31:0] xl_vaddr,
    output logic        xl_done,
    output logic        xl_miss,
    output logic        xl_mod,
    output logic        xl_uncached,
    output logic [31:0] xl_paddr,
    input  logic        op_valid,
    input  logic [1:0]  op_code,
    input  logic        reg_wr,
    input  logic [4:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int IDX_W = $clog2(ENTRIES);

    tlb_op_e            op;
    tlb_tag_t           tag_q;
    tlb_data_t          data_q;
    logic               slot_fail_q;
    logic [IDX_W-1:0]   slot_q;
    logic [31:0]        fault_q;
    logic [IDX_W-1:0]   rand_val;

    tlb_entry_t         ent_q [ENTRIES];
    logic [ENTRIES-1:0] look_match, probe_match;
    logic               look_hit, probe_hit;
    logic [IDX_W-1:0]   look_idx, probe_idx;

    logic               arr_we;
    logic [IDX_W-1:0]   arr_widx;
    tlb_entry_t         look_e;
    logic               look_ok, look_fault;
    logic               unused_wbits;

    assign op           = tlb_op_e'(op_code);
    assign arr_we       = op_valid && ((op == OP_WIDX) || (op == OP_WRND));
    assign arr_widx     = (op == OP_WRND) ? rand_val : slot_q;
    assign unused_wbits = ^reg_wdata;

    tlb_random_ctr #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_rand (
        .clk   (clk),
        .rst   (rst),
        .value (rand_val)
    );

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk         (clk),
        .rst         (rst),
        .we          (arr_we),
        .widx        (arr_widx),
        .wentry      ('{tag: tag_q, data: data_q}),
        .look_vpn    (xl_vaddr[31:OFF_W]),
        .probe_vpn   (tag_q.vpn),
        .asid        (tag_q.asid),
        .ent_q       (ent_q),
        .look_match  (look_match),
        .probe_match (probe_match)
    );

    tlb_prio_enc #(.N(ENTRIES)) u_look_enc (
        .match (look_match),
        .hit   (look_hit),
        .idx   (look_idx)
    );

    tlb_prio_enc #(.N(ENTRIES)) u_probe_enc (
        .match (probe_match),
        .hit   (probe_hit),
        .idx   (probe_idx)
    );

    assign look_e     = ent_q[look_idx];
    assign look_ok    = look_hit && look_e.data.valid;
    assign look_fault = !look_ok || (xl_store && !look_e.data.dirty);

    // Translation result, one register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            xl_done     <= 1'b0;
            xl_miss     <= 1'b0;
            xl_mod      <= 1'b0;
            xl_uncached <= 1'b0;
            xl_paddr    <= '0;
            fault_q     <= '0;
        end else begin
            xl_done <= xl_valid;
            if (xl_valid) begin
                xl_miss     <= !look_ok;
                xl_mod      <= look_ok && look_fault;
                xl_uncached <= look_ok && look_e.data.nc;
                xl_paddr    <= look_fault ? '0 : {look_e.data.pfn, xl_vaddr[OFF_W-1:0]};
                if (look_fault)
                    fault_q <= xl_vaddr;
            end else begin
                xl_miss     <= 1'b0;
                xl_mod      <= 1'b0;
                xl_uncached <= 1'b0;
            end
        end
    end

    // Software registers and management commands
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q       <= '0;
            data_q      <= '0;
            slot_q      <= '0;
            slot_fail_q <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    CP_SLOT: begin
                        slot_q      <= reg_wdata[SLOT_LSB +: IDX_W];
                        slot_fail_q <= 1'b0;
                    end
                    CP_TAG:  tag_q  <= '{vpn: reg_wdata[31:OFF_W],
                                         asid: reg_wdata[ASID_LSB +: ASID_W]};
                    CP_DATA: data_q <= '{pfn: reg_wdata[31:OFF_W], nc: reg_wdata[11],
                                         dirty: reg_wdata[10], valid: reg_wdata[9],
                                         glob: reg_wdata[8]};
                    default: ;
                endcase
            end
            if (op_valid) begin
                case (op)
                    OP_READ: begin
                        tag_q  <= ent_q[slot_q].tag;
                        data_q <= ent_q[slot_q].data;
                    end
                    OP_PROBE: begin
                        slot_fail_q <= !probe_hit;
                        slot_q      <= probe_hit ? probe_idx : '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            CP_SLOT: begin
                reg_rdata[31]                 = slot_fail_q;
                reg_rdata[SLOT_LSB +: IDX_W]  = slot_q;
            end
            CP_RAND:  reg_rdata[SLOT_LSB +: IDX_W] = rand_val;
            CP_DATA:  reg_rdata = pack_data(data_q);
            CP_FAULT: reg_rdata = fault_q;
            CP_TAG:   reg_rdata = pack_tag(tag_q);
            default:  reg_rdata = '0;
        endcase
    end

    assert_miss_records_R4: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && !look_hit) |=> (xl_miss && (fault_q == $past(xl_vaddr))));

    assert_hit_keeps_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && !look_fault) |=> $stable(fault_q));

    assert_miss_zero_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (xl_done && (xl_miss || xl_mod)) |-> (xl_paddr == '0));

    assert_probe_fail_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == OP_PROBE) && !probe_hit) |=> (slot_fail_q && (slot_q == '0)));

    assert_probe_found_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == OP_PROBE) && probe_hit && !reg_wr)
            |=> (!slot_fail_q && (slot_q == $past(probe_idx))));

    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
        xl_done |-> $onehot0({xl_miss, xl_mod}));

endmodule

// File: tb/tlb_mmu_test.sv
`timescale 1ns/1ps
module tlb_mmu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xl_valid = 1'b0, xl_store = 1'b0;
    logic [31:0] xl_vaddr = '0;
    logic        xl_done, xl_miss, xl_mod, xl_uncached;
    logic [31:0] xl_paddr;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_sel = 5'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    tlb_mmu uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_reg(input logic [4:0] s, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] s, output logic [31:0] d);
        reg_sel = s; #0.5; d = reg_rdata;
    endtask

    task automatic do_op(input logic [1:0] c);
        op_valid = 1'b1; op_code = c;
        tick();
        op_valid = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic st);
        xl_valid = 1'b1; xl_vaddr = va; xl_store = st;
        tick();
        xl_valid = 1'b0; xl_store = 1'b0;
    endtask

    function automatic logic [19:0] vpn_of(input int i); return 20'h40000 + 20'(i * 37); endfunction
    function automatic logic [19:0] pfn_of(input int i); return 20'hA0000 ^ 20'(i * 131); endfunction
    function automatic logic g_of(input int i); return (i % 2) == 0; endfunction
    function automatic logic d_of(input int i); return (i % 3) != 0; endfunction
    function automatic logic n_of(input int i); return (i % 4) == 0; endfunction
    function automatic logic [5:0] asid_of(input int i); return g_of(i) ? 6'd9 : 6'd5; endfunction
    function automatic logic [31:0] hi_of(input int i); return {vpn_of(i), asid_of(i), 6'b0}; endfunction
    function automatic logic [31:0] lo_of(input int i);
        return {pfn_of(i), n_of(i), d_of(i), 1'b1, g_of(i), 8'b0};
    endfunction
    function automatic logic [31:0] slot_word(input int i); return 32'(i) << 8; endfunction
    function automatic logic [31:0] next_rand(input logic [31:0] r);
        return (r == slot_word(8)) ? slot_word(63) : r - slot_word(1);
    endfunction

    task automatic put_entry(input int slot, input logic [31:0] hi, input logic [31:0] lo);
        wr_reg(5'd0, slot_word(slot));
        wr_reg(5'd10, hi);
        wr_reg(5'd2, lo);
        do_op(2'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, r;
        logic [31:0] va;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        rd_reg(5'd0, d);  check("R13 slot", d, 32'h0);
        rd_reg(5'd10, d); check("R13 tag", d, 32'h0);
        rd_reg(5'd2, d);  check("R13 data", d, 32'h0);
        rd_reg(5'd8, d);  check("R13 fault", d, 32'h0);
        lookup(32'h0000_0123, 1'b0);
        check("R13 empty miss", {31'b0, xl_miss}, 32'h1);
        check("R13 done R1", {31'b0, xl_done}, 32'h1);
        check("R4 fault on empty", (rd_val(5'd8)), 32'h0000_0123);

        // R10 counter sweep
        rd_reg(5'd1, r);
        for (int k = 0; k < 130; k++) begin
            tick();
            rd_reg(5'd1, d);
            check("R10 counter", d, next_rand(r));
            r = d;
        end

        // R12 writes to counter and fault register ignored
        rd_reg(5'd1, r);
        wr_reg(5'd1, 32'h0);
        rd_reg(5'd1, d); check("R12 counter read-only", d, next_rand(r));
        wr_reg(5'd8, 32'hFFFF_FFFF);
        rd_reg(5'd8, d); check("R12 fault read-only", d, 32'h0000_0123);
        wr_reg(5'd10, 32'hFFFF_FFFF);
        rd_reg(5'd10, d); check("R12 tag layout", d, 32'hFFFF_FFC0);
        wr_reg(5'd2, 32'hFFFF_FFFF);
        rd_reg(5'd2, d); check("R12 data layout", d, 32'hFFFF_FF00);
        wr_reg(5'd0, 32'hFFFF_FFFF);
        rd_reg(5'd0, d); check("R12 slot layout", d, 32'h0000_3F00);

        // R7 fill every slot
        for (int i = 0; i < 64; i++) put_entry(i, hi_of(i), lo_of(i));

        // R1 R2 lookups with identifier 5
        wr_reg(5'd10, {20'h0, 6'd5, 6'b0});
        for (int i = 0; i < 64; i++) begin
            for (int o = 0; o < 3; o++) begin
                logic [11:0] off;
                off = (o == 0) ? 12'h000 : (o == 1) ? 12'hFFF : 12'(i * 53);
                lookup({vpn_of(i), off}, 1'b0);
                check("R1 translate", xl_paddr, {pfn_of(i), off});
                check("R1 uncached", {30'b0, xl_miss, xl_uncached}, {31'b0, n_of(i)});
            end
        end

        // R4 fault register unchanged after hits
        rd_reg(5'd8, d); check("R4 unchanged on hit", d, 32'h0000_0123);

        // R5 stores
        for (int i = 0; i < 64; i++) begin
            va = {vpn_of(i), 12'h7A4};
            lookup(va, 1'b1);
            check("R5 modify flag", {30'b0, xl_mod, xl_miss}, {30'b0, !d_of(i), 1'b0});
            check("R5 store addr", xl_paddr, d_of(i) ? {pfn_of(i), 12'h7A4} : 32'h0);
            if (!d_of(i)) begin
                rd_reg(5'd8, d); check("R4 fault on modify", d, va);
            end
        end

        // R2 identifier 6: private entries miss, global hit
        wr_reg(5'd10, {20'h0, 6'd6, 6'b0});
        for (int i = 0; i < 64; i++) begin
            va = {vpn_of(i), 12'(i * 7 + 1)};
            lookup(va, 1'b0);
            check("R2 id filter", {31'b0, xl_miss}, {31'b0, !g_of(i)});
            if (!g_of(i)) begin
                check("R3 miss zero addr", xl_paddr, 32'h0);
                rd_reg(5'd8, d); check("R4 fault on miss", d, va);
            end
        end

        // R6 indexed read of all slots
        for (int i = 0; i < 64; i++) begin
            wr_reg(5'd0, slot_word(i));
            do_op(2'd0);
            rd_reg(5'd10, d); check("R6 read tag", d, hi_of(i));
            rd_reg(5'd2, d);  check("R6 read data", d, lo_of(i));
        end

        // R9 probe every slot
        for (int i = 0; i < 64; i++) begin
            wr_reg(5'd10, hi_of(i));
            do_op(2'd3);
            rd_reg(5'd0, d); check("R9 probe hit", d, slot_word(i));
        end
        wr_reg(5'd10, {20'hFFFFF, 6'd5, 6'b0});
        do_op(2'd3);
        rd_reg(5'd0, d); check("R9 probe miss", d, 32'h8000_0000);
        wr_reg(5'd10, {vpn_of(1), 6'd6, 6'b0});
        do_op(2'd3);
        rd_reg(5'd0, d); check("R9 probe wrong id", d, 32'h8000_0000);
        wr_reg(5'd10, {vpn_of(2), 6'd33, 6'b0});
        do_op(2'd3);
        rd_reg(5'd0, d); check("R9 probe global", d, slot_word(2));

        // R11 lowest slot wins
        put_entry(40, {20'h12345, 6'd0, 6'b0}, {20'h0BEEF, 4'b0110, 8'b0});
        put_entry(10, {20'h12345, 6'd0, 6'b0}, {20'h0CAFE, 4'b0111, 8'b0});
        wr_reg(5'd10, {20'h12345, 6'd0, 6'b0});
        lookup(32'h1234_5ABC, 1'b0);
        check("R11 lowest lookup", xl_paddr, 32'h0CAF_EABC);
        do_op(2'd3);
        rd_reg(5'd0, d); check("R11 lowest probe", d, slot_word(10));
        // R3 invalid low slot shadows valid high slot
        put_entry(10, {20'h12345, 6'd0, 6'b0}, {20'h0CAFE, 4'b0101, 8'b0});
        wr_reg(5'd10, {20'h0, 6'd0, 6'b0});
        lookup(32'h1234_5010, 1'b0);
        check("R3 invalid entry miss", {31'b0, xl_miss}, 32'h1);
        check("R3 invalid zero addr", xl_paddr, 32'h0);

        // R8 random write
        for (int k = 0; k < 4; k++) begin
            wr_reg(5'd10, {20'h77700 + 20'(k), 6'd0, 6'b0});
            wr_reg(5'd2, {20'h55500 + 20'(k), 4'b0111, 8'b0});
            repeat (k * 3) tick();
            rd_reg(5'd1, r);
            do_op(2'd2);
            wr_reg(5'd0, r);
            do_op(2'd0);
            rd_reg(5'd2, d); check("R8 random slot data", d, {20'h55500 + 20'(k), 4'b0111, 8'b0});
            rd_reg(5'd10, d); check("R8 random slot tag", d, {20'h77700 + 20'(k), 6'd0, 6'b0});
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [31:0] rd_val(input logic [4:0] s);
        return (s == reg_sel) ? reg_rdata : 32'hDEAD_BEEF;
    endfunction

    initial reg_sel = 5'd8;

endmodule